// File: doc/BRIEF.md
# Memory-Resident Command Ring Consumer

This block drains a ring of fixed-size commands that software places in system memory. Software programs a base register with the ring's 4 KiB-aligned address and its size in pages. It then advances a write index, while the hardware keeps a read index. Whenever the ring is enabled, not stalled, both indices lie inside the ring and they differ, the consumer fetches the first 64-bit word of the entry at the read index. It takes the command code from the low byte of that word. It then either passes the command to an external handler or completes it by itself.

When a command completes successfully the read index moves forward by one entry and wraps at the end of the ring. A command that the handler rejects, or a fetch that returns a bus error, sets a sticky stall flag and leaves the read index on the failing entry. The execution of individual commands and the memory fabric sit outside this block.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset, `q_enabled` is 0, `rd_reg` and `wr_reg` are 0, and neither `mem_req` nor `cmd_valid` is asserted.
- R2: Each fetch presents `mem_addr` = ring base + 32 × read index. A fetch and a handler request are never pending at the same time.
- R3: A control write (`cfg_sel`=0) with `cfg_wdata[0]`=1 enables the ring, clears the read index and the stall flag, and starts processing. With bit 0 = 0 it disables the ring. While the ring is disabled, nothing is fetched.
- R4: The ring holds (size + 1) × 128 entries, where size is base-register bits [7:0]. If either index is at or beyond that count, nothing is fetched and the read index does not move.
- R5: Each successful command sets the read index to (read + 1) modulo the entry count. Processing continues until the read index equals the write index.
- R6: If the handler answers `cmd_ok`=0, or a fetch answers `mem_err`=1, the stall flag (`rd_reg[0]`) is set and the read index stays on that entry. No further fetch happens until an enable write or a base write clears the flag.
- R7: A base write (`cfg_sel`=1) is ignored while the ring is enabled. While the ring is disabled, it loads the size from bits [7:0] and the address from bits [ADDR_W-1:12], and it clears both indices and the stall flag.
- R8: Codes 0x03, 0x04, 0x08 to 0x0D and 0x0F go to the handler on `cmd_code` and `cmd_addr` (the entry address). They are held until `cmd_ready` and are finished by a `cmd_done` pulse that carries `cmd_ok`.
- R9: Code 0x05 (synchronise) and every code not listed in R8 complete at once as successful, without a handler request.
- R10: A write-index write (`cfg_sel`=2) takes the index from bits [OFF_W+4:5]. Bit 0 (retry) and all other bits are dropped. `wr_reg` shows the index in bits [OFF_W+4:5]. Writes with `cfg_sel`=3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 control, 1 base, 2 write index, 3 no effect |
| cfg_wdata | input | 64 | Configuration write data |
| q_enabled | output | 1 | Ring enable state |
| rd_reg | output | 32 | Read index in [OFF_W+4:5], stall flag in bit 0 |
| wr_reg | output | 32 | Write index in [OFF_W+4:5] |
| mem_req | output | 1 | Entry fetch request, held until `mem_rvalid` |
| mem_addr | output | ADDR_W | Fetch byte address |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_err | input | 1 | Fetch bus error, qualified by `mem_rvalid` |
| mem_rdata | input | 64 | First doubleword of the entry |
| cmd_valid | output | 1 | Handler request |
| cmd_ready | input | 1 | Handler accepts the request |
| cmd_code | output | 8 | Command code |
| cmd_addr | output | ADDR_W | Entry address of the command |
| cmd_done | input | 1 | Handler completion pulse |
| cmd_ok | input | 1 | Completion status, qualified by `cmd_done` |

## Verification
The bench uses the default parameters: ADDR_W = 48 and SIZE_W = 8, which allows rings of up to 32768 entries. Most traffic runs with size 0, a 128-entry ring. This keeps wrap-around at index 127 short enough to cross several times and makes out-of-range write indices such as 200 easy to reach. A final phase switches to size 1, a 256-entry ring. There the same index 200 becomes legal and the wrap point moves to 255, which shows that the entry count follows the size field.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT
  } cq_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_WPTR = 2'd2;

  localparam int ENTRY_SHIFT  = 5;    // 32-byte entries
  localparam int PAGE_ENTRIES = 128;  // 4096 / 32

  // codes that need the external handler; everything else retires at once
  function automatic logic needs_handler(input logic [7:0] code);
    case (code)
      8'h03, 8'h04, 8'h08, 8'h09, 8'h0A,
      8'h0B, 8'h0C, 8'h0D, 8'h0F: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  function automatic int unsigned ring_entries(input int unsigned size_f);
    return (size_f + 1) * PAGE_ENTRIES;
  endfunction

  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned cnt);
    return (idx + 1 >= cnt) ? 0 : idx + 1;
  endfunction

  function automatic logic [63:0] entry_addr(input logic [63:0] base,
                                             input int unsigned idx);
    return base + (64'(idx) << ENTRY_SHIFT);
  endfunction

endpackage

// File: rtl/cq_regs.sv
module cq_regs
  import cq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 8,
  localparam int OFF_W = SIZE_W + 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [63:0]       cfg_wdata,
  input  logic              adv_i,
  input  logic              stall_i,
  output logic              en_o,
  output logic              stalled_o,
  output logic [OFF_W-1:0]  rd_idx_o,
  output logic [OFF_W-1:0]  wr_idx_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              go_o
);

  logic                en_q, stall_q;
  logic [OFF_W-1:0]    rd_q, wr_q;
  logic [SIZE_W-1:0]   size_q;
  logic [ADDR_W-13:0]  page_q;
  logic [OFF_W:0]      cnt;
  logic [OFF_W-1:0]    rd_nxt;

  // named write events
  logic ctrl_wr, base_wr, base_wr_taken, wptr_wr;
  assign ctrl_wr       = cfg_we && (cfg_sel == SEL_CTRL);
  assign base_wr       = cfg_we && (cfg_sel == SEL_BASE);
  assign base_wr_taken = base_wr && !en_q;
  assign wptr_wr       = cfg_we && (cfg_sel == SEL_WPTR);

  assign cnt    = (OFF_W+1)'(ring_entries(32'(size_q)));
  assign rd_nxt = OFF_W'(ring_next(32'(rd_q), 32'(cnt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      stall_q <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
      size_q  <= '0;
      page_q  <= '0;
    end else begin
      if (adv_i)   rd_q    <= rd_nxt;
      if (stall_i) stall_q <= 1'b1;
      // software writes take priority over the engine's update
      if (ctrl_wr) begin
        en_q <= cfg_wdata[0];
        if (cfg_wdata[0]) begin
          rd_q    <= '0;
          stall_q <= 1'b0;
        end
      end
      if (base_wr_taken) begin
        size_q  <= cfg_wdata[SIZE_W-1:0];
        page_q  <= cfg_wdata[ADDR_W-1:12];
        rd_q    <= '0;
        wr_q    <= '0;
        stall_q <= 1'b0;
      end
      if (wptr_wr) wr_q <= cfg_wdata[OFF_W+4:5];
    end
  end

  assign en_o      = en_q;
  assign stalled_o = stall_q;
  assign rd_idx_o  = rd_q;
  assign wr_idx_o  = wr_q;
  assign base_o    = {page_q, 12'h000};
  assign go_o      = en_q && !stall_q && (rd_q != wr_q) &&
                     ({1'b0, rd_q} < cnt) && ({1'b0, wr_q} < cnt);

  AST_BASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && en_q) |=> $stable(base_o)); // R7
  AST_BASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr_taken && !adv_i) |=> (rd_q == '0 && wr_q == '0 && !stall_q)); // R7
  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !cfg_we) |=> stall_q); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !cfg_we) |=> $stable(rd_q)); // R6

endmodule

// File: rtl/cq_fsm.sv
module cq_fsm
  import cq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic              mem_err,
  input  logic [63:0]       mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_done,
  input  logic              cmd_ok,
  output logic              adv_o,
  output logic              stall_o
);

  cq_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        code_q;
  logic [ADDR_W-1:0] cur_addr;

  assign cur_addr = ADDR_W'(entry_addr(64'(base_i), 32'(rd_idx_i)));

  // named events
  logic fetch_done, fetch_ok, fetch_local, issue_hs, cmd_finish;
  assign fetch_done  = (state_q == ST_FETCH) && mem_rvalid;
  assign fetch_ok    = fetch_done && !mem_err;
  assign fetch_local = fetch_ok && !needs_handler(mem_rdata[7:0]);
  assign issue_hs    = (state_q == ST_ISSUE) && cmd_ready;
  assign cmd_finish  = (state_q == ST_WAIT) && cmd_done;

  assign adv_o   = fetch_local || (cmd_finish && cmd_ok);
  assign stall_o = (fetch_done && mem_err) || (cmd_finish && !cmd_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      code_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (go_i) begin
                    addr_q  <= cur_addr;
                    state_q <= ST_FETCH;
                  end
        ST_FETCH: if (fetch_done) begin
                    code_q  <= mem_rdata[7:0];
                    state_q <= (fetch_ok && !fetch_local) ? ST_ISSUE : ST_IDLE;
                  end
        ST_ISSUE: if (issue_hs)   state_q <= ST_WAIT;
        ST_WAIT:  if (cmd_finish) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q == ST_FETCH);
  assign mem_addr  = addr_q;
  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_code  = code_q;
  assign cmd_addr  = addr_q;

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == cur_addr)); // R2
  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_addr))); // R8
  AST_FETCH_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(go_i)); // R4

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [63:0]       cfg_wdata,
  output logic              q_enabled,
  output logic [31:0]       rd_reg,
  output logic [31:0]       wr_reg,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic              mem_err,
  input  logic [63:0]       mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_done,
  input  logic              cmd_ok
);

  localparam int OFF_W = SIZE_W + 7;

  logic              adv, stall, stalled, go;
  logic [OFF_W-1:0]  rd_idx, wr_idx;
  logic [ADDR_W-1:0] base;

  cq_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .adv_i(adv), .stall_i(stall),
    .en_o(q_enabled), .stalled_o(stalled),
    .rd_idx_o(rd_idx), .wr_idx_o(wr_idx),
    .base_o(base), .go_o(go)
  );

  cq_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go_i(go), .base_i(base), .rd_idx_i(rd_idx),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_done(cmd_done), .cmd_ok(cmd_ok),
    .adv_o(adv), .stall_o(stall)
  );

  assign rd_reg = 32'({rd_idx, 5'b00000}) | {31'b0, stalled};
  assign wr_reg = 32'({wr_idx, 5'b00000});

  AST_FETCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(q_enabled)); // R3
  AST_FETCH_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (rd_idx != wr_idx)); // R5

endmodule

// File: tb/cmdq_consumer_tb.sv
module cmdq_consumer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [63:0] cfg_wdata = '0;
  logic        q_enabled;
  logic [31:0] rd_reg, wr_reg;
  logic        mem_req;
  logic [47:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic        mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_code;
  logic [47:0] cmd_addr;
  logic        cmd_done = 1'b0;
  logic        cmd_ok = 1'b0;

  always #10 clk = ~clk;

  cmdq_consumer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .q_enabled(q_enabled), .rd_reg(rd_reg),
    .wr_reg(wr_reg), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_done(cmd_done), .cmd_ok(cmd_ok)
  );

  int n_chk = 0, n_fail = 0;
  int code_tab[128];
  int err_idx = -1, fail_idx = -1;
  int got_n = 0, exp_n = 0, fetch_cnt = 0, exp_fetch = 0;
  int got_code[512], exp_code[512];
  logic [47:0] got_addr[512], exp_addr[512];
  logic [47:0] exp_base = '0;
  int exp_cnt = 128, cur_rd = 0, cur_wr = 0;
  bit exp_en = 0, cur_stall = 0;

  function automatic bit tb_handled(int c);
    return (c == 3) || (c == 4) || (c == 15) || (c >= 8 && c <= 13);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_req && !mem_rvalid) begin
      automatic int idx = int'((mem_addr >> 5) & 48'h7F);
      mem_rvalid = 1'b1;
      mem_err    = (idx == err_idx);
      mem_rdata  = {32'($urandom), 24'($urandom), 8'(code_tab[idx])};
      fetch_cnt++;
    end else begin
      mem_rvalid = 1'b0;
      mem_err    = 1'b0;
    end
  end

  // handler responder
  always @(negedge clk) begin
    if (cmd_done) begin
      cmd_done = 1'b0;
    end else if (cmd_ready) begin
      cmd_ready = 1'b0;
      cmd_done  = 1'b1;
      cmd_ok    = (int'((cmd_addr >> 5) & 48'h7F) != fail_idx);
    end else if (cmd_valid) begin
      cmd_ready = 1'b1;
      if (got_n < 512) begin
        got_code[got_n] = int'(cmd_code);
        got_addr[got_n] = cmd_addr;
      end
      got_n++;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic predict();
    int i = cur_rd;
    exp_n = 0; exp_fetch = 0;
    if (!exp_en || cur_stall || cur_rd >= exp_cnt || cur_wr >= exp_cnt) return;
    while (i != cur_wr) begin
      exp_fetch++;
      if (i == err_idx) begin cur_stall = 1; break; end
      if (tb_handled(code_tab[i % 128])) begin
        exp_code[exp_n] = code_tab[i % 128];
        exp_addr[exp_n] = exp_base + 48'(i) * 48'd32;
        exp_n++;
        if (i == fail_idx) begin cur_stall = 1; break; end
      end
      i = (i + 1) % exp_cnt;
    end
    cur_rd = i;
  endtask

  task automatic apply(logic [1:0] sel, logic [63:0] data, string tag);
    int f0 = fetch_cnt;
    int span = 0;
    int rd0 = cur_rd;
    case (sel)
      2'd0: begin exp_en = data[0]; if (data[0]) begin cur_rd = 0; cur_stall = 0; rd0 = 0; end end
      2'd1: if (!exp_en) begin
              exp_base = {data[47:12], 12'h000};
              exp_cnt = (int'(data[7:0]) + 1) * 128;
              cur_rd = 0; cur_wr = 0; cur_stall = 0; rd0 = 0;
            end
      2'd2: cur_wr = int'(data[19:5]);
      default: ;
    endcase
    got_n = 0;
    predict();
    if (cur_wr < exp_cnt && rd0 < exp_cnt) span = (cur_wr - rd0 + exp_cnt) % exp_cnt;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (span * 8 + 40) @(negedge clk);
    check({tag, " fetch count"}, 64'(fetch_cnt - f0), 64'(exp_fetch));
    check({tag, " handler requests"}, 64'(got_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      check({tag, " R8 code"}, 64'(got_code[k]), 64'(exp_code[k]));
      check({tag, " R2 addr"}, 64'(got_addr[k]), 64'(exp_addr[k]));
    end
    check({tag, " rd_reg"}, 64'(rd_reg), 64'((cur_rd << 5) | int'(cur_stall)));
    check({tag, " R10 wr_reg"}, 64'(wr_reg), 64'(cur_wr << 5));
    check({tag, " enable"}, 64'(q_enabled), 64'(exp_en));
  endtask

  localparam logic [63:0] BASE_A = 64'h0000_1234_5000;
  localparam logic [63:0] BASE_B = 64'h0000_ABCD_E000;
  localparam int CODES[9] = '{3, 4, 8, 9, 10, 11, 12, 13, 15};

  initial begin
    void'($urandom(32'h5EED_C0DE));
    for (int k = 0; k < 128; k++) begin
      case ($urandom % 4)
        0, 3:    code_tab[k] = CODES[$urandom % 9];
        1:       code_tab[k] = 5;
        default: code_tab[k] = int'($urandom % 256);
      endcase
    end
    code_tab[1] = 8'h05; code_tab[2] = 8'h77; code_tab[3] = 8'h03; code_tab[8] = 8'h09;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enable", 64'(q_enabled), 64'd0);
    check("R1 rd_reg", 64'(rd_reg), 64'd0);
    check("R1 wr_reg", 64'(wr_reg), 64'd0);
    check("R1 mem_req", 64'(mem_req), 64'd0);
    check("R1 cmd_valid", 64'(cmd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(2'd1, BASE_A, "R7 base load disabled");
    apply(2'd2, (64'd6 << 5) | 64'h1 | (64'h1 << 25), "R10 R3 wptr while disabled");
    apply(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R10 sel3 no effect");
    apply(2'd0, 64'd1, "R3 R9 enable start");
    apply(2'd1, BASE_B, "R7 base locked while enabled");
    apply(2'd2, 64'd20 << 5, "R7 R8 old base kept");
    apply(2'd2, 64'd3 << 5, "R5 wrap at 127");
    for (int k = 0; k < 6; k++)
      apply(2'd2, 64'($urandom % 128) << 5, "R5 R8 random window");
    apply(2'd2, 64'd2 << 5, "R5 directed");
    apply(2'd2, 64'd200 << 5, "R4 wptr out of range");
    apply(2'd2, 64'd5 << 5, "R4 resume in range");
    fail_idx = 8;
    apply(2'd2, 64'd12 << 5, "R6 handler failure");
    apply(2'd2, 64'd14 << 5, "R6 stall holds");
    fail_idx = -1;
    apply(2'd0, 64'd1, "R3 re-enable clears stall");
    err_idx = 16;
    apply(2'd2, 64'd20 << 5, "R6 fetch bus error");
    err_idx = -1;
    apply(2'd0, 64'd0, "R3 disable");
    apply(2'd1, BASE_B | 64'd1, "R7 base write clears offsets");
    apply(2'd2, 64'd10 << 5, "R3 no fetch while disabled");
    apply(2'd0, 64'd1, "R3 R2 enable on new base");
    apply(2'd2, 64'd200 << 5, "R4 larger ring accepts 200");
    apply(2'd2, 64'd5 << 5, "R5 wrap at 255");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule